// File: doc/BRIEF.md
# Coherent Byte-Lane Access to Wide Peripheral Registers

This block sits between a CPU with an 8-bit data bus and a bank of 16-bit and 24-bit peripheral registers. A byte bus cannot move a wide value in one access. The block gives the CPU a consistent view of each wide register anyway. A single pair of staging bytes is shared by every wide register in the bank.

**Reads.** Reading the least significant byte of a register does two things at once. It returns that byte, and it freezes the register's upper bytes into the staging pair. The later reads of the upper bytes are served from that frozen copy. This holds even if the hardware side has changed the register in the meantime.

**Writes.** Writing an upper byte only fills the staging pair. Writing the least significant byte then commits the whole value in a single clock.

**Direct access and hardware updates.** Both staging bytes also have addresses of their own, so software can save and restore them. The peripheral logic can load any register through a hardware update port. The live contents of all registers are presented on a flat output vector.

**Address map.** Register *i* occupies a four-byte window at address 4·*i*:
- offset 0 is the low byte;
- offset 1 is the middle byte;
- offset 2 is the high byte, present only on 24-bit registers;
- offset 3 is unused.

The first `N16` registers are 16-bit and the remaining `N24` are 24-bit. The low staging byte sits at address 4·(`N16`+`N24`) and the high staging byte at the next address. With the defaults, registers 0 and 1 are 16-bit at 0x00 and 0x04, registers 2 and 3 are 24-bit at 0x08 and 0x0C, and the staging bytes are at 0x10 and 0x11. Read data appears on the output one clock after the read strobe.

Top module: `wide_reg_access`

## Requirements
- R1: After reset, every register, both staging bytes and the read data output are zero.
- R2: A read of offset 0 returns the register's low byte on the next clock. In the same clock it copies the middle byte into the low staging byte. For a 24-bit register it also copies the high byte into the high staging byte.
- R3: A read of offset 1 returns the low staging byte, not the live middle byte. A hardware change to the register after the offset-0 read does not show in this read.
- R4: A read of offset 2 of a 24-bit register returns the high staging byte.
- R5: A bus write to offset 1 loads the low staging byte. A bus write to offset 2 of a 24-bit register loads the high staging byte. Neither write changes any register.
- R6: A bus write to offset 0 commits one full value in one clock, visible on `live_o` at the next clock:
  - for a 24-bit register, {high staging, low staging, bus byte};
  - for a 16-bit register, {low staging, bus byte} with the upper byte of its slot zero.
- R7: The staging bytes are read and written directly at addresses 4·NREG (low) and 4·NREG+1 (high).
- R8: Reads of offset 3, of offset 2 of a 16-bit register, or of any address above the staging bytes return 0x00. Writes to those addresses change no register and no staging byte.
- R9: A hardware update loads the indexed register on the next clock, with the upper byte cleared for a 16-bit register. A bus commit to the same register in the same cycle takes priority over it.
- R10: In a cycle after no read strobe, the read data output is 0x00.
- R11: When read and write strobes are both high, only the write is performed. There is no staging capture, and the read data output is 0x00 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_rd_i | input | 1 | Bus read strobe |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 8 | Write byte |
| bus_rdata_o | output | 8 | Read byte, one clock after the strobe |
| hw_we_i | input | 1 | Hardware update strobe |
| hw_idx_i | input | IDX_W | Register index for the hardware update |
| hw_data_i | input | 24 | Hardware update value |
| live_o | output | NREG*24 | Live register contents, register i in bits [24i+23:24i] |

## Verification
The stimulus table is built around sequences that separate a staged value from a live one:
- **Read coherence.** A low-byte read is followed by a hardware update and then an upper-byte read. This sequence distinguishes a design that forwards the live register from one that serves the frozen copy.
- **Write staging and commit.** Upper-byte writes followed by a low-byte write, on both a 16-bit and a 24-bit register, show whether the commit assembles the staged bytes and clears the missing byte.
- **Collisions.** A hardware update in the same cycle as a commit, and a combined read-and-write strobe, expose a wrong priority.
- **Quiet addresses.** Reads and writes to the unused addresses, followed by read-back of the staging bytes, show whether those accesses leak into any state.

// File: rtl/wra_pkg.sv
package wra_pkg;
    localparam int BYTE_W = 8;
    localparam int SLOT_W = 24;

    typedef enum logic [1:0] {
        SEL_B0   = 2'd0,
        SEL_B1   = 2'd1,
        SEL_B2   = 2'd2,
        SEL_NONE = 2'd3
    } byte_sel_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } stage_t;

    function automatic logic [SLOT_W-1:0] slot_mask(input logic wide24);
        return wide24 ? 24'hFF_FFFF : 24'h00_FFFF;
    endfunction
endpackage

// File: rtl/wra_decode.sv
module wra_decode
    import wra_pkg::*;
#(
    parameter int N16    = 2,
    parameter int N24    = 2,
    parameter int ADDR_W = 5,
    localparam int NREG  = N16 + N24,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output byte_sel_e         sel_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              wide24_o,
    output logic              stg_lo_hit_o,
    output logic              stg_hi_hit_o
);
    localparam logic [ADDR_W-3:0] WIN_LIMIT = (ADDR_W-2)'(NREG);
    localparam logic [ADDR_W-1:0] STG_ADDR  = ADDR_W'(4 * NREG);
    localparam logic [IDX_W:0]    FIRST24   = (IDX_W+1)'(N16);

    logic [ADDR_W-3:0] win;
    logic [1:0]        off;

    always_comb begin
        win          = addr_i[ADDR_W-1:2];
        off          = addr_i[1:0];
        sel_o        = SEL_NONE;
        idx_o        = '0;
        wide24_o     = 1'b0;
        stg_lo_hit_o = (addr_i == STG_ADDR);
        stg_hi_hit_o = (addr_i == STG_ADDR + ADDR_W'(1));
        if (win < WIN_LIMIT) begin
            idx_o    = win[IDX_W-1:0];
            wide24_o = ({1'b0, win[IDX_W-1:0]} >= FIRST24);
            unique case (off)
                2'd0: sel_o = SEL_B0;
                2'd1: sel_o = SEL_B1;
                2'd2: sel_o = wide24_o ? SEL_B2 : SEL_NONE;
                default: sel_o = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/wra_stage.sv
module wra_stage
    import wra_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  byte_sel_e         sel_i,
    input  logic              wide24_i,
    input  logic              stg_lo_hit_i,
    input  logic              stg_hi_hit_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [SLOT_W-1:0] live_slot_i,
    output stage_t            stage_o
);
    stage_t stage_d, stage_q;

    always_comb begin
        stage_d = stage_q;
        if (wr_en_i) begin
            if (stg_lo_hit_i || sel_i == SEL_B1) stage_d.lo = wdata_i;
            if (stg_hi_hit_i || sel_i == SEL_B2) stage_d.hi = wdata_i;
        end else if (rd_en_i && sel_i == SEL_B0) begin
            stage_d.lo = live_slot_i[15:8];
            if (wide24_i) stage_d.hi = live_slot_i[23:16];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= stage_d;
    end

    assign stage_o = stage_q;
endmodule

// File: rtl/wra_bank.sv
module wra_bank
    import wra_pkg::*;
#(
    parameter int N16    = 2,
    parameter int N24    = 2,
    localparam int NREG  = N16 + N24,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   commit_i,
    input  logic [IDX_W-1:0]       commit_idx_i,
    input  logic [SLOT_W-1:0]      commit_val_i,
    input  logic                   hw_we_i,
    input  logic [IDX_W-1:0]       hw_idx_i,
    input  logic [SLOT_W-1:0]      hw_data_i,
    input  logic [IDX_W-1:0]       rd_idx_i,
    output logic [SLOT_W-1:0]      rd_slot_o,
    output logic [NREG*SLOT_W-1:0] live_o
);
    logic [NREG-1:0][SLOT_W-1:0] regs_d, regs_q, mask_w;

    for (genvar g = 0; g < NREG; g++) begin : g_mask
        assign mask_w[g] = slot_mask(g >= N16);
    end

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NREG; i++) begin
            if (hw_we_i && hw_idx_i == IDX_W'(i))
                regs_d[i] = hw_data_i & mask_w[i];
            if (commit_i && commit_idx_i == IDX_W'(i))
                regs_d[i] = commit_val_i & mask_w[i];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    assign rd_slot_o = regs_q[rd_idx_i];
    assign live_o    = regs_q;
endmodule

// File: rtl/wide_reg_access.sv
module wide_reg_access
    import wra_pkg::*;
#(
    parameter int N16    = 2,
    parameter int N24    = 2,
    parameter int ADDR_W = 5,
    localparam int NREG  = N16 + N24,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   bus_rd_i,
    input  logic                   bus_wr_i,
    input  logic [ADDR_W-1:0]      bus_addr_i,
    input  logic [7:0]             bus_wdata_i,
    output logic [7:0]             bus_rdata_o,
    input  logic                   hw_we_i,
    input  logic [IDX_W-1:0]       hw_idx_i,
    input  logic [23:0]            hw_data_i,
    output logic [NREG*24-1:0]     live_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] rdata;
    } rd_state_t;

    rd_state_t          rd_d, rd_q;
    byte_sel_e          sel;
    logic [IDX_W-1:0]   idx;
    logic               wide24, stg_lo_hit, stg_hi_hit;
    logic               rd_en, wr_en, commit;
    stage_t             stage;
    logic [SLOT_W-1:0]  live_slot, commit_val;
    logic [BYTE_W-1:0]  mux_byte;

    assign wr_en  = bus_wr_i;
    assign rd_en  = bus_rd_i && !bus_wr_i;
    assign commit = wr_en && sel == SEL_B0;
    assign commit_val = {wide24 ? stage.hi : 8'h00, stage.lo, bus_wdata_i};

    wra_decode #(.N16(N16), .N24(N24), .ADDR_W(ADDR_W)) u_decode (
        .addr_i       (bus_addr_i),
        .sel_o        (sel),
        .idx_o        (idx),
        .wide24_o     (wide24),
        .stg_lo_hit_o (stg_lo_hit),
        .stg_hi_hit_o (stg_hi_hit)
    );

    wra_stage u_stage (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .rd_en_i      (rd_en),
        .wr_en_i      (wr_en),
        .sel_i        (sel),
        .wide24_i     (wide24),
        .stg_lo_hit_i (stg_lo_hit),
        .stg_hi_hit_i (stg_hi_hit),
        .wdata_i      (bus_wdata_i),
        .live_slot_i  (live_slot),
        .stage_o      (stage)
    );

    wra_bank #(.N16(N16), .N24(N24)) u_bank (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .commit_i     (commit),
        .commit_idx_i (idx),
        .commit_val_i (commit_val),
        .hw_we_i      (hw_we_i),
        .hw_idx_i     (hw_idx_i),
        .hw_data_i    (hw_data_i),
        .rd_idx_i     (idx),
        .rd_slot_o    (live_slot),
        .live_o       (live_o)
    );

    always_comb begin
        unique case (sel)
            SEL_B0:  mux_byte = live_slot[7:0];
            SEL_B1:  mux_byte = stage.lo;
            SEL_B2:  mux_byte = stage.hi;
            default: mux_byte = stg_lo_hit ? stage.lo :
                                stg_hi_hit ? stage.hi : 8'h00;
        endcase
        rd_d.rdata = rd_en ? mux_byte : 8'h00;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) rd_q <= '0;
        else         rd_q <= rd_d;
    end

    assign bus_rdata_o = rd_q.rdata;
endmodule

// File: rtl/wide_reg_access_chk.sv
module wide_reg_access_chk #(
    parameter int N16    = 2,
    parameter int N24    = 2,
    parameter int ADDR_W = 5,
    localparam int NREG  = N16 + N24,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 bus_rd_i,
    input logic                 bus_wr_i,
    input logic [ADDR_W-1:0]    bus_addr_i,
    input logic [7:0]           bus_wdata_i,
    input logic [7:0]           bus_rdata_o,
    input logic                 hw_we_i,
    input logic [IDX_W-1:0]     hw_idx_i,
    input logic [23:0]          hw_data_i,
    input logic [NREG*24-1:0]   live_o
);
    localparam logic [ADDR_W-3:0] WIN_LIMIT = (ADDR_W-2)'(NREG);
    localparam logic [ADDR_W-1:0] STG_ADDR  = ADDR_W'(4 * NREG);
    localparam logic [IDX_W:0]    FIRST24   = (IDX_W+1)'(N16);
    localparam logic [IDX_W:0]    IDX_LIM   = (IDX_W+1)'(NREG);

    logic [ADDR_W-3:0] win;
    logic [IDX_W-1:0]  widx;
    logic              in_map, lo_wr, stg_addr, quiet_addr;
    logic [IDX_W-1:0]  wr_idx_q, hw_idx_q;
    logic [7:0]        lo_of_wr;
    logic [23:0]       slot_of_hw, hw_mask;

    assign win        = bus_addr_i[ADDR_W-1:2];
    assign widx       = win[IDX_W-1:0];
    assign in_map     = win < WIN_LIMIT;
    assign lo_wr      = bus_wr_i && in_map && bus_addr_i[1:0] == 2'd0;
    assign stg_addr   = bus_addr_i == STG_ADDR || bus_addr_i == STG_ADDR + ADDR_W'(1);
    assign quiet_addr = !stg_addr && !(in_map && (bus_addr_i[1:0] == 2'd0 ||
                        bus_addr_i[1:0] == 2'd1 ||
                        (bus_addr_i[1:0] == 2'd2 && {1'b0, widx} >= FIRST24)));

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wr_idx_q <= '0;
            hw_idx_q <= '0;
        end else begin
            wr_idx_q <= widx;
            hw_idx_q <= hw_idx_i;
        end
    end

    assign lo_of_wr   = live_o[wr_idx_q*24 +: 8];
    assign slot_of_hw = live_o[hw_idx_q*24 +: 24];
    assign hw_mask    = ({1'b0, hw_idx_q} >= FIRST24) ? 24'hFF_FFFF : 24'h00_FFFF;

    // R10, R11: no read strobe, or a read overridden by a write, leaves zero
    p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bus_rd_i || bus_wr_i) |=> bus_rdata_o == 8'h00);

    // R6: low-byte write lands in the register one clock later
    p_commit_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lo_wr |=> lo_of_wr == $past(bus_wdata_i));

    // R5: upper-byte writes only stage
    p_stage_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && in_map && bus_addr_i[1:0] != 2'd0 && !hw_we_i) |=> $stable(live_o));

    // R8: quiet addresses change no register and read as zero
    p_quiet_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && quiet_addr && !hw_we_i) |=> $stable(live_o));
    p_quiet_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && !bus_wr_i && quiet_addr) |=> bus_rdata_o == 8'h00);

    // R9: a hardware update not overridden by a commit lands masked
    p_hw_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hw_we_i && {1'b0, hw_idx_i} < IDX_LIM && !(lo_wr && widx == hw_idx_i))
        |=> slot_of_hw == ($past(hw_data_i) & hw_mask));
endmodule

bind wide_reg_access wide_reg_access_chk #(.N16(N16), .N24(N24), .ADDR_W(ADDR_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_rd_i    (bus_rd_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .hw_we_i     (hw_we_i),
    .hw_idx_i    (hw_idx_i),
    .hw_data_i   (hw_data_i),
    .live_o      (live_o)
);

// File: tb/wide_reg_access_test.sv
module wide_reg_access_test;
    localparam int N16 = 2, N24 = 2, ADDR_W = 5;
    localparam int NREG = N16 + N24;
    localparam int IDX_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_rd = 1'b0, bus_wr = 1'b0, hw_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic [IDX_W-1:0]  hw_idx = '0;
    logic [23:0]       hw_data = '0;
    logic [NREG*24-1:0] live;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wide_reg_access #(.N16(N16), .N24(N24), .ADDR_W(ADDR_W)) uut (
        .clk_i(clk), .rst_ni(rst_n),
        .bus_rd_i(bus_rd), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .hw_we_i(hw_we), .hw_idx_i(hw_idx), .hw_data_i(hw_data),
        .live_o(live)
    );

    typedef struct packed {
        logic [1:0]  op;    // 0 hardware update, 1 read, 2 write
        logic [7:0]  addr;  // bus address, or register index for op 0
        logic [23:0] data;
        logic        chk;
        logic [7:0]  exp;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 8'h02, 24'hA1B2C3, 1'b0, 8'h00},
        '{2'd1, 8'h08, 24'h0,      1'b1, 8'hC3},  // R2 low byte of live value
        '{2'd0, 8'h02, 24'h112233, 1'b0, 8'h00},
        '{2'd1, 8'h09, 24'h0,      1'b1, 8'hB2},  // R3 frozen middle byte
        '{2'd1, 8'h0A, 24'h0,      1'b1, 8'hA1},  // R4 frozen high byte
        '{2'd1, 8'h10, 24'h0,      1'b1, 8'hB2},  // R7 staging low direct
        '{2'd2, 8'h05, 24'h5A,     1'b0, 8'h00},  // R5 stage middle
        '{2'd2, 8'h04, 24'h7E,     1'b0, 8'h00},  // R6 commit 16-bit
        '{2'd1, 8'h04, 24'h0,      1'b1, 8'h7E},
        '{2'd1, 8'h05, 24'h0,      1'b1, 8'h5A},
        '{2'd2, 8'h0E, 24'h99,     1'b0, 8'h00},
        '{2'd2, 8'h0D, 24'h88,     1'b0, 8'h00},
        '{2'd2, 8'h0C, 24'h77,     1'b0, 8'h00},  // R6 commit 24-bit
        '{2'd1, 8'h0C, 24'h0,      1'b1, 8'h77},
        '{2'd1, 8'h0E, 24'h0,      1'b1, 8'h99},
        '{2'd1, 8'h11, 24'h0,      1'b1, 8'h99},  // R7 staging high direct
        '{2'd1, 8'h0D, 24'h0,      1'b1, 8'h88},
        '{2'd1, 8'h03, 24'h0,      1'b1, 8'h00},  // R8 offset 3
        '{2'd1, 8'h02, 24'h0,      1'b1, 8'h00},  // R8 byte 2 of 16-bit
        '{2'd1, 8'h1F, 24'h0,      1'b1, 8'h00},  // R8 above staging
        '{2'd2, 8'h11, 24'h42,     1'b0, 8'h00},
        '{2'd1, 8'h11, 24'h0,      1'b1, 8'h42}   // R7 write then read
    };

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive one cycle at a negedge, return at the next negedge with strobes idle
    task automatic cycle(input logic rd, input logic wr, input logic [7:0] addr,
                         input logic [7:0] wd, input logic hw, input logic [1:0] hidx,
                         input logic [23:0] hd);
        bus_rd = rd; bus_wr = wr; bus_addr = addr[ADDR_W-1:0]; bus_wdata = wd;
        hw_we = hw; hw_idx = hidx; hw_data = hd;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; hw_we = 1'b0;
    endtask

    function automatic logic [23:0] slot(input int i);
        return live[i*24 +: 24];
    endfunction

    logic [NREG*24-1:0] snap;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 rdata", {16'h0, bus_rdata}, 24'h0);
        check("R1 live", live[23:0] | live[47:24] | live[71:48] | live[95:72], 24'h0);
        cycle(1'b1, 1'b0, 8'h10, 8'h0, 1'b0, 2'd0, 24'h0);
        check("R1 staging low", {16'h0, bus_rdata}, 24'h0);
        cycle(1'b1, 1'b0, 8'h11, 8'h0, 1'b0, 2'd0, 24'h0);
        check("R1 staging high", {16'h0, bus_rdata}, 24'h0);

        for (int v = 0; v < NV; v++) begin
            case (VEC[v].op)
                2'd0: cycle(1'b0, 1'b0, 8'h0, 8'h0, 1'b1, VEC[v].addr[1:0], VEC[v].data);
                2'd1: cycle(1'b1, 1'b0, VEC[v].addr, 8'h0, 1'b0, 2'd0, 24'h0);
                default: cycle(1'b0, 1'b1, VEC[v].addr, VEC[v].data[7:0], 1'b0, 2'd0, 24'h0);
            endcase
            if (VEC[v].chk)
                check($sformatf("vector %0d R2-R8 table", v), {16'h0, bus_rdata}, {16'h0, VEC[v].exp});
        end

        // R6 committed wide values on live_o
        check("R6 reg1 16-bit commit", slot(1), 24'h005A7E);
        check("R6 reg3 24-bit commit", slot(3), 24'h998877);
        check("R9 reg2 hw value", slot(2), 24'h112233);

        // R10 idle cycle after a read gives zero
        cycle(1'b1, 1'b0, 8'h0C, 8'h0, 1'b0, 2'd0, 24'h0);
        check("R10 read before idle", {16'h0, bus_rdata}, 24'h000077);
        cycle(1'b0, 1'b0, 8'h0C, 8'h0, 1'b0, 2'd0, 24'h0);
        check("R10 idle zero", {16'h0, bus_rdata}, 24'h0);

        // R9 16-bit hardware update clears upper byte
        cycle(1'b0, 1'b0, 8'h0, 8'h0, 1'b1, 2'd0, 24'hFFEEDD);
        check("R9 16-bit mask", slot(0), 24'h00EEDD);

        // R9 bus commit beats same-cycle hardware update
        cycle(1'b0, 1'b1, 8'h01, 8'h12, 1'b0, 2'd0, 24'h0);
        cycle(1'b0, 1'b1, 8'h00, 8'h34, 1'b1, 2'd0, 24'h00AAAA);
        check("R9 commit priority", slot(0), 24'h001234);

        // R11 read and write together: write only, no capture, zero data
        cycle(1'b1, 1'b1, 8'h11, 8'h55, 1'b0, 2'd0, 24'h0);
        check("R11 rdata zero", {16'h0, bus_rdata}, 24'h0);
        cycle(1'b1, 1'b0, 8'h11, 8'h0, 1'b0, 2'd0, 24'h0);
        check("R11 write done", {16'h0, bus_rdata}, 24'h000055);
        cycle(1'b1, 1'b1, 8'h08, 8'h00, 1'b0, 2'd0, 24'h0);
        cycle(1'b1, 1'b0, 8'h10, 8'h0, 1'b0, 2'd0, 24'h0);
        check("R11 no capture", {16'h0, bus_rdata}, 24'h000012);

        // R8 writes to quiet addresses touch nothing
        snap = live;
        cycle(1'b0, 1'b1, 8'h03, 8'hEE, 1'b0, 2'd0, 24'h0);
        cycle(1'b0, 1'b1, 8'h02, 8'hEE, 1'b0, 2'd0, 24'h0);
        cycle(1'b0, 1'b1, 8'h1F, 8'hEE, 1'b0, 2'd0, 24'h0);
        check("R8 live unchanged", {23'h0, live == snap}, 24'h1);
        cycle(1'b1, 1'b0, 8'h10, 8'h0, 1'b0, 2'd0, 24'h0);
        check("R8 staging low kept", {16'h0, bus_rdata}, 24'h000012);
        cycle(1'b1, 1'b0, 8'h11, 8'h0, 1'b0, 2'd0, 24'h0);
        check("R8 staging high kept", {16'h0, bus_rdata}, 24'h000055);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule